// File: doc/BRIEF.md
# Cascadable Dual 8-bit Match Timer

This block holds two 8-bit up-counters. Each counter has its own 8-bit compare value. A counter counts tick enables from 0 up to its compare value and clears to 0 on the tick after. That same tick is a match: it sets a sticky interrupt flag and flips a square-wave toggle. The toggle reaches its pin only when the pin's output enable is set. The count tick comes from a shared prescaler that divides the system clock. It can instead come from an external clock input, which is synchronized and edge-detected.

The two counters can be chained into one 16-bit counter. Timer 0 is the low byte and timer 1 is the high byte. A match is then declared only when both bytes equal their compare bytes in the same tick. That match raises timer 0's flag and flips timer 1's pin. Timer 1's flag stays quiet, and so does timer 0's pin.

Configuration arrives as plain input levels and pulses, for example from a register block.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, both interrupt flags and both output pins are 0.
- R2: Timer 0 clock select codes: 000=÷2, 001=÷4, 010=÷16, 011=÷64, 100=÷256, 101=÷1024, 110=÷4096 of the system clock. With prescale N and compare value C, the pin flips every N×(C+1) system clock cycles.
- R3: A running counter steps 0,1,…,C and clears to 0 on the next tick. That clearing tick is the match.
- R4: Timer 0 clock select 111 takes one tick per rising edge of the external clock input, after a two-flop synchronizer.
- R5: In independent mode, each timer flips its own pin and sets its own flag on its own match.
- R6: Cascaded mode is active only when the cascade bit is 1 and timer 1's clock select is 11. Timer 0 then carries into timer 1 when it wraps from 0xFF. A match occurs only when both bytes equal their compare bytes at once, so the pin period is N×(C1×256+C0+1) cycles.
- R7: In cascaded mode a match sets timer 0's flag and flips timer 1's pin. Timer 1's flag is never set, and timer 0's pin never flips.
- R8: With its output enable low, a pin is driven 0. The internal toggle keeps running.
- R9: With a timer's enable low, its count is held: no match, no pin change.
- R10: A start pulse clears the counter(s) to 0. A start on timer 0 in cascaded mode clears both bytes.
- R11: A flag stays set until its clear pulse. A match in the same cycle as a clear leaves the flag set.
- R12: Timer 1 clock select codes: 00=÷2, 01=÷64, 10=÷1024, 11=timer 0's tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External count clock (asynchronous) |
| t0_sel | input | 3 | Timer 0 clock select |
| t1_sel | input | 2 | Timer 1 clock select |
| cascade | input | 1 | Request 16-bit chained mode |
| t0_en | input | 1 | Timer 0 run enable |
| t1_en | input | 1 | Timer 1 run enable (ignored when cascaded) |
| t0_start | input | 1 | Pulse: clear timer 0 (both bytes when cascaded) |
| t1_start | input | 1 | Pulse: clear timer 1 |
| t0_cmp | input | 8 | Timer 0 compare value |
| t1_cmp | input | 8 | Timer 1 compare value |
| t0_oe | input | 1 | Timer 0 pin enable |
| t1_oe | input | 1 | Timer 1 pin enable |
| t0_flag_clr | input | 1 | Pulse: clear timer 0 flag |
| t1_flag_clr | input | 1 | Pulse: clear timer 1 flag |
| t0_flag | output | 1 | Timer 0 interrupt flag |
| t1_flag | output | 1 | Timer 1 interrupt flag |
| t0_out | output | 1 | Timer 0 toggle pin |
| t1_out | output | 1 | Timer 1 toggle pin |

## Verification
The bench sweeps every prescaler code of both timers and a range of compare values, including 0. It measures the exact distance between pin edges. A counter that clears one tick early or late, or a wrong divider tap, shows up as a miscounted interval.

Cascaded mode is checked for the 16-bit period, for the pin and flag routing, and for mode gating by timer 1's select. A design that matched on the low byte alone would flip about 256 times too fast. Misrouting would flip the wrong pin or raise timer 1's flag.

Further checks cover hold with the enable low, pin masking, flag stickiness, and external clock ticks. They catch designs that keep counting when stopped, leak the toggle while the pin is disabled, drop flags, or count external clock levels instead of edges.

// File: rtl/dual_timer_pkg.sv
// Package: shared constants and clock-select decoding for the dual match timer.
// Assumes a prescaler counter of at least 12 bits so the ÷4096 tap exists.
package dual_timer_pkg;

    localparam int CNT_W = 8;
    localparam int PRE_W = 12;

    // Timer 0 clock select code that picks the external clock.
    localparam logic [2:0] SEL_EXT = 3'b111;
    // Timer 1 clock select code that borrows timer 0's tick.
    localparam logic [1:0] SEL_T1_CHAIN = 2'b11;

    // Map a timer 0 select code to the prescaler tap index (tap k divides by 2^(k+1)).
    function automatic int t0_tap(input logic [2:0] sel);
        case (sel)
            3'b000:  return 0;
            3'b001:  return 1;
            3'b010:  return 3;
            3'b011:  return 5;
            3'b100:  return 7;
            3'b101:  return 9;
            default: return 11;
        endcase
    endfunction

    // Map a timer 1 select code (00..10) to the prescaler tap index.
    function automatic int t1_tap(input logic [1:0] sel);
        case (sel)
            2'b00:   return 0;
            2'b01:   return 5;
            default: return 9;
        endcase
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
// Module: free-running power-of-two prescaler plus external clock edge detector.
// Produces one-cycle tick taps, where tap k pulses once every 2^(k+1) cycles.
// Assumes ext_clk is asynchronous and its high and low phases each last at least two clk cycles.
module tick_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    output logic [PRE_W-1:0] taps,
    output logic             ext_tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [2:0]       ext_sync;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_cnt <= '0;
        else        pre_cnt <= pre_cnt + 1'b1;
    end

    // Tap k is high while the low k+1 bits are all ones: one cycle per 2^(k+1).
    for (genvar k = 0; k < PRE_W; k++) begin : g_tap
        assign taps[k] = &pre_cnt[k:0];
    end

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[1:0], ext_clk};
    end

    assign ext_tick = ext_sync[1] & ~ext_sync[2];

    // An external tick never lasts two cycles in a row.
    p_ext_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |=> !ext_tick);

endmodule

// File: rtl/byte_counter.sv
// Module: one byte of the match counter.
// Steps by one on an enabled tick when step is high, and clears on start or on a wrap request.
// Assumes the parent decides the wrap condition (own match or full 16-bit match).
module byte_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             start,
    input  logic             step,
    input  logic             wrap_clr,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             eq
);

    logic adv;
    assign adv = tick & en;

    // Count register: start wins, then wrap-to-zero, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (start)            count <= '0;
        else if (adv && wrap_clr)  count <= '0;
        else if (adv && step)      count <= count + 1'b1;
    end

    assign eq = (count == cmp);

    p_clear_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wrap_clr) |=> (count == '0));
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == '0));
    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !adv) |=> $stable(count));

endmodule

// File: rtl/dual_match_timer.sv
// Module: top of the dual 8-bit match timer with an optional 16-bit cascade.
// Selects each timer's tick, wires the two byte counters independently or chained,
// and keeps the sticky flags and toggle flops.
// Assumes configuration inputs are synchronous to clk. Start and clear inputs are one-cycle pulses.
module dual_match_timer
    import dual_timer_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int PW = PRE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_clk,
    input  logic [2:0]   t0_sel,
    input  logic [1:0]   t1_sel,
    input  logic         cascade,
    input  logic         t0_en,
    input  logic         t1_en,
    input  logic         t0_start,
    input  logic         t1_start,
    input  logic [W-1:0] t0_cmp,
    input  logic [W-1:0] t1_cmp,
    input  logic         t0_oe,
    input  logic         t1_oe,
    input  logic         t0_flag_clr,
    input  logic         t1_flag_clr,
    output logic         t0_flag,
    output logic         t1_flag,
    output logic         t0_out,
    output logic         t1_out
);

    logic [PW-1:0] taps;
    logic          ext_tick;
    logic          tick0, tick1;
    logic          casc;
    logic [W-1:0]  lo_cnt, hi_cnt;
    logic          lo_eq, hi_eq;
    logic          lo_wrap, hi_wrap, hi_step;
    logic          en1, start1;
    logic          run0, run1;
    logic          ev_lo, ev_hi, ev_full;
    logic          t0_tog, t1_tog;

    tick_prescaler #(.PRE_W(PW)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk  (ext_clk),
        .taps     (taps),
        .ext_tick (ext_tick)
    );

    // Tick selection for both timers.
    always_comb begin
        tick0 = (t0_sel == SEL_EXT) ? ext_tick : taps[t0_tap(t0_sel)];
        tick1 = (t1_sel == SEL_T1_CHAIN) ? tick0 : taps[t1_tap(t1_sel)];
    end

    assign casc = cascade && (t1_sel == SEL_T1_CHAIN);

    // Controls for the two bytes in each mode.
    always_comb begin
        run0    = tick0 & t0_en & ~t0_start;
        en1     = casc ? t0_en : t1_en;
        start1  = t1_start | (casc & t0_start);
        run1    = tick1 & en1 & ~start1;
        ev_lo   = ~casc & run0 & lo_eq;
        ev_hi   = ~casc & run1 & hi_eq;
        ev_full =  casc & run0 & lo_eq & hi_eq;
        lo_wrap = casc ? (lo_eq & hi_eq) : lo_eq;
        hi_wrap = casc ? (lo_eq & hi_eq) : hi_eq;
        hi_step = casc ? (&lo_cnt) : 1'b1;
    end

    byte_counter #(.CNT_W(W)) u_lo (
        .clk (clk), .rst_n (rst_n), .tick (tick0), .en (t0_en),
        .start (t0_start), .step (1'b1), .wrap_clr (lo_wrap),
        .cmp (t0_cmp), .count (lo_cnt), .eq (lo_eq)
    );

    byte_counter #(.CNT_W(W)) u_hi (
        .clk (clk), .rst_n (rst_n), .tick (tick1), .en (en1),
        .start (start1), .step (hi_step), .wrap_clr (hi_wrap),
        .cmp (t1_cmp), .count (hi_cnt), .eq (hi_eq)
    );

    // Sticky interrupt flags: a match beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t0_flag <= 1'b0;
            t1_flag <= 1'b0;
        end else begin
            t0_flag <= (ev_lo | ev_full) | (t0_flag & ~t0_flag_clr);
            t1_flag <= ev_hi | (t1_flag & ~t1_flag_clr);
        end
    end

    // Toggle flops: timer 1 also flips on a full 16-bit match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t0_tog <= 1'b0;
            t1_tog <= 1'b0;
        end else begin
            t0_tog <= t0_tog ^ ev_lo;
            t1_tog <= t1_tog ^ (ev_hi | ev_full);
        end
    end

    assign t0_out = t0_tog & t0_oe;
    assign t1_out = t1_tog & t1_oe;

    p_flag_match_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_lo || ev_full) && t0_flag_clr) |=> t0_flag);
    p_no_t1_flag_cascaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && !t1_flag) |=> !t1_flag);
    p_t0_pin_quiet_cascaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        casc |=> $stable(t0_tog));
    p_full_needs_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && t0_en && !t0_start && !t1_start && tick0 && !(lo_eq && hi_eq) && !(&lo_cnt))
            |=> $stable(hi_cnt));

endmodule

// File: tb/dual_match_timer_test.sv
module dual_match_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic [2:0] t0_sel = '0;
    logic [1:0] t1_sel = '0;
    logic       cascade = 1'b0;
    logic       t0_en = 1'b0, t1_en = 1'b0;
    logic       t0_start = 1'b0, t1_start = 1'b0;
    logic [7:0] t0_cmp = '0, t1_cmp = '0;
    logic       t0_oe = 1'b0, t1_oe = 1'b0;
    logic       t0_flag_clr = 1'b0, t1_flag_clr = 1'b0;
    logic       t0_flag, t1_flag, t0_out, t1_out;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  ext_run = 1'b0;

    dual_match_timer uut (
        .clk (clk), .rst_n (rst_n), .ext_clk (ext_clk),
        .t0_sel (t0_sel), .t1_sel (t1_sel), .cascade (cascade),
        .t0_en (t0_en), .t1_en (t1_en), .t0_start (t0_start), .t1_start (t1_start),
        .t0_cmp (t0_cmp), .t1_cmp (t1_cmp), .t0_oe (t0_oe), .t1_oe (t1_oe),
        .t0_flag_clr (t0_flag_clr), .t1_flag_clr (t1_flag_clr),
        .t0_flag (t0_flag), .t1_flag (t1_flag), .t0_out (t0_out), .t1_out (t1_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // External clock: flips every 3 cycles while enabled, so one rising edge per 6 cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (ext_run) begin
                repeat (2) @(negedge clk);
                ext_clk = ~ext_clk;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        t0_start = 1'b1;
        t1_start = 1'b1;
        @(negedge clk);
        t0_start = 1'b0;
        t1_start = 1'b0;
    endtask

    // Wait for the chosen pin to change. Returns the cycle stamp, or -1 on timeout.
    task automatic wait_edge(input bit which, input int limit, output int at);
        logic v;
        v = which ? t1_out : t0_out;
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if ((which ? t1_out : t0_out) != v) begin
                at = cyc;
                return;
            end
        end
    endtask

    // Measure the distance between two pin edges and compare it with exp.
    task automatic check_period(input bit which, input int exp, input string tag);
        int a, b, c;
        wait_edge(which, 2 * exp + 40, c);
        wait_edge(which, 2 * exp + 40, a);
        wait_edge(which, 2 * exp + 40, b);
        check(c >= 0 && a >= 0 && b >= 0 && (b - a) == exp, tag, b - a, exp);
    endtask

    // Watch a pin for n cycles and count how many times it changes.
    task automatic count_changes(input bit which, input int n, output int changes);
        logic v;
        changes = 0;
        v = which ? t1_out : t0_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((which ? t1_out : t0_out) != v) begin
                changes++;
                v = which ? t1_out : t0_out;
            end
        end
    endtask

    initial begin
        int div0 [7] = '{2, 4, 16, 64, 256, 1024, 4096};
        int div1 [3] = '{2, 64, 1024};
        int ch, a, b;

        repeat (3) @(negedge clk);
        check(t0_flag == 0 && t1_flag == 0, "R1 flags after reset", t0_flag + t1_flag, 0);
        check(t0_out == 0 && t1_out == 0, "R1 pins after reset", t0_out + t1_out, 0);
        rst_n = 1'b1;

        // R2 / R3 / R5: timer 0 through every prescaler code.
        t0_oe = 1'b1;
        t1_oe = 1'b1;
        t0_en = 1'b1;
        t0_cmp = 8'd2;
        for (int s = 0; s < 7; s++) begin
            t0_sel = 3'(s);
            pulse_start();
            check_period(1'b0, div0[s] * 3, $sformatf("R2 t0 sel %0d", s));
        end
        check(t0_flag == 1, "R5 t0 flag set by match", t0_flag, 1);

        // R3: compare value sweep at ÷2, including 0.
        t0_sel = 3'b000;
        for (int c = 0; c < 16; c++) begin
            t0_cmp = 8'(c);
            pulse_start();
            check_period(1'b0, 2 * (c + 1), $sformatf("R3 cmp %0d", c));
        end

        // R12 / R5: timer 1 on its own selects. Timer 0 is stopped meanwhile.
        t0_en = 1'b0;
        t1_en = 1'b1;
        t1_cmp = 8'd1;
        for (int s = 0; s < 3; s++) begin
            t1_sel = 2'(s);
            pulse_start();
            check_period(1'b1, div1[s] * 2, $sformatf("R12 t1 sel %0d", s));
        end
        check(t1_flag == 1, "R5 t1 flag set by match", t1_flag, 1);

        // R12: t1 select 11 follows timer 0's tick (÷16).
        t0_sel = 3'b010;
        t1_sel = 2'b11;
        pulse_start();
        check_period(1'b1, 16 * 2, "R12 t1 borrows t0 tick");

        // R11: flags stay set without a clear; a clear pulse drops them.
        t1_en = 1'b0;
        repeat (50) @(negedge clk);
        check(t0_flag == 1 && t1_flag == 1, "R11 flags sticky", t0_flag + t1_flag, 2);
        t0_flag_clr = 1'b1;
        t1_flag_clr = 1'b1;
        @(negedge clk);
        t0_flag_clr = 1'b0;
        t1_flag_clr = 1'b0;
        @(negedge clk);
        check(t0_flag == 0 && t1_flag == 0, "R11 flags cleared", t0_flag + t1_flag, 0);

        // R6 / R7: cascade at ÷2, 16-bit compare 0x0103 gives 2*260 cycles.
        t0_sel = 3'b000;
        t1_sel = 2'b11;
        cascade = 1'b1;
        t0_en = 1'b1;
        t1_en = 1'b0;
        t0_cmp = 8'h03;
        t1_cmp = 8'h01;
        pulse_start();
        check_period(1'b1, 2 * 260, "R6 cascade period");
        check(t0_flag == 1, "R7 cascade sets t0 flag", t0_flag, 1);
        check(t1_flag == 0, "R7 cascade leaves t1 flag", t1_flag, 0);
        count_changes(1'b0, 1200, ch);
        check(ch == 0, "R7 t0 pin quiet in cascade", ch, 0);

        // R6: cascade bit without select 11 stays independent.
        t1_sel = 2'b00;
        t1_en = 1'b1;
        pulse_start();
        check_period(1'b0, 2 * 4, "R6 cascade gated by t1 select");
        cascade = 1'b0;

        // R9: enable low holds the count, so no pin change.
        t0_cmp = 8'd3;
        pulse_start();
        t0_en = 1'b0;
        count_changes(1'b0, 3000, ch);
        check(ch == 0, "R9 hold while disabled", ch, 0);
        t0_en = 1'b1;
        check_period(1'b0, 8, "R9 resumes after enable");

        // R10: after a start, the first flip comes (cmp+1) ticks later at ÷2.
        t0_cmp = 8'd50;
        pulse_start();
        a = cyc;
        wait_edge(1'b0, 400, b);
        check(b >= 0 && (b - a) >= 100 && (b - a) <= 102, "R10 start restarts count", b - a, 101);

        // R8: pin masked while disabled, toggling continues underneath.
        t0_cmp = 8'd1;
        t0_oe = 1'b0;
        count_changes(1'b0, 200, ch);
        check(ch == 0 && t0_out == 0, "R8 pin low when disabled", ch, 0);
        t0_oe = 1'b1;
        check_period(1'b0, 4, "R8 pin returns when enabled");

        // R4: external clock, one rising edge per 6 cycles, cmp 2 gives 18.
        ext_run = 1'b1;
        t0_sel = 3'b111;
        t0_cmp = 8'd2;
        repeat (20) @(negedge clk);
        pulse_start();
        check_period(1'b0, 18, "R4 external clock edges");
        t0_cmp = 8'd0;
        pulse_start();
        check_period(1'b0, 6, "R4 external clock cmp 0");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #1_500_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule